// File: doc/BRIEF.md
# Time-Qualified Pattern Trigger

This block decides when a capture should start, working from a few logic channels that have already been sliced against their thresholds and registered once per sample clock. Software loads a set of configuration inputs, pulses `arm`, and the block raises `trig` when the selected condition is met. `trig` then holds until the next arm or reset. Four conditions are available. Immediate fires as soon as the block is armed. Edge fires on a chosen polarity of one chosen channel. Pattern fires on entering, or on leaving, a high/low/don't-care pattern across the channels. Time-qualified fires on the exit edge of the pattern, but only when the pattern lasted long enough, briefly enough, or within a window.

An event count asks for the nth qualifying event before firing. In the time-qualified mode only the first of those n patterns has to meet the duration rule; the later ones only have to be valid pattern exits. A pattern shorter than a programmable minimum length is never recognized. An optional timeout fires the trigger on its own when nothing has matched for a set number of samples, and it flags that case on `trig_auto`.

The controller is a four-state machine. IDLE waits for `arm`. WAIT_FIRST waits for the first qualifying event. COUNT_REST counts the remaining events. FIRED holds the trigger. Its transitions are as follows. Any state goes to WAIT_FIRST on arm (arm). WAIT_FIRST goes to FIRED when immediate mode is selected (instant), on a qualified event when the count is one (first_done), or on timeout (timeout). WAIT_FIRST goes to COUNT_REST on a qualified event when more are needed (first_seen). COUNT_REST goes to FIRED on the last counted event (nth_done), in immediate mode (instant), or on timeout (timeout).

Top module: `tqp_trigger`

## Requirements
- R1: After reset, `trig`, `trig_auto` and `armed` are all 0.
- R2: With `mode_cfg`=0 (immediate), `armed` is 1 after the edge that samples `arm`, and `trig` is 1 after the next edge.
- R3: With `mode_cfg`=1 (edge), only the transition of channel `edge_sel` in the polarity given by `edge_rise` (1 = low to high, 0 = high to low) is an event. Changes on other channels and the opposite polarity are ignored. A channel change sampled at edge e shows on `trig` after edge e+1.
- R4: A channel i takes part in the pattern when `pat_care[i]`=1, and must then equal `pat_val[i]`. Channels with `pat_care[i]`=0 are don't-care.
- R5: With `mode_cfg`=2 (pattern), `pat_exit`=0 fires when the pattern has been held for the minimum length. `pat_exit`=1 fires on the first sample after the pattern ends, and never while the pattern is held.
- R6: A pattern held for fewer than `min_len` consecutive samples is not recognized in modes 2 and 3. A `min_len` of 0 acts as 1.
- R7: With `mode_cfg`=3, a pattern exit of length L samples qualifies by `qual_rule` as follows. 0: L > `dur_lo`. 1: L < `dur_hi`. 2 or 3: `dur_lo` <= L <= `dur_hi`.
- R8: A pattern that fails its duration rule leaves detection ready, so a new pattern starting on the very next sample is measured from its own start.
- R9: The trigger fires on the `evt_n`-th event, where an `evt_n` of 0 acts as 1. In mode 3 only the first counted pattern must satisfy the duration rule, and later valid exits count whatever their length.
- R10: With `auto_en`=1, if no event fires the trigger, `trig` and `trig_auto` rise after edge k+1+`auto_limit`, where edge k is the edge that sampled `arm`. A trigger caused by a real event leaves `trig_auto` at 0.
- R11: Once high, `trig` stays high until the next arm or reset. An arm clears `trig` and `trig_auto` and restarts detection.
- R12: While not armed, no channel activity raises `trig`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low reset |
| arm | input | 1 | Start or restart detection |
| chan | input | NCH | Thresholded channel levels |
| mode_cfg | input | 2 | 0 immediate, 1 edge, 2 pattern, 3 time-qualified |
| edge_sel | input | SEL_W | Channel watched in edge mode |
| edge_rise | input | 1 | 1 rising, 0 falling |
| pat_care | input | NCH | 1 = channel takes part in pattern |
| pat_val | input | NCH | Required level of cared channels |
| pat_exit | input | 1 | Pattern mode: 0 on entry, 1 on exit |
| qual_rule | input | 2 | Duration rule selector |
| dur_lo | input | DUR_W | Lower duration bound in samples |
| dur_hi | input | DUR_W | Upper duration bound in samples |
| min_len | input | DUR_W | Shortest recognized pattern |
| evt_n | input | EVT_W | Events needed to fire |
| auto_en | input | 1 | Enable timeout trigger |
| auto_limit | input | AUTO_W | Timeout length in samples |
| trig | output | 1 | Trigger, held until re-armed |
| trig_auto | output | 1 | Trigger came from the timeout |
| armed | output | 1 | Waiting for events |

## Verification
The bench sweeps pulse lengths across the boundaries of each duration rule. A design that counted from the wrong sample would be off by one at `dur_lo` or `dur_hi`, and would misfire exactly at those lengths. It counts event sequences against every small `evt_n`, including 0. An event counter that started from the wrong value or forgot to treat 0 as 1 would fire one pulse early or late. It feeds a short, failing pattern before a long one when the event count is above one. A design that applied the duration rule to every pattern, or that counted the failed pattern, would then fire at the wrong point. Edge mode is driven with the opposite polarity and with activity on the unselected channels, so a wrong channel index or polarity would fire early. The exact cycle of the timeout is also checked, which exposes an off-by-one in the timer.

// File: rtl/tqp_pkg.sv
package tqp_pkg;

    typedef enum logic [1:0] {
        MODE_IMM   = 2'd0,
        MODE_EDGE  = 2'd1,
        MODE_PAT   = 2'd2,
        MODE_TQUAL = 2'd3
    } trig_mode_e;

    typedef enum logic [1:0] {
        RULE_GT     = 2'd0,
        RULE_LT     = 2'd1,
        RULE_IN     = 2'd2,
        RULE_IN_ALT = 2'd3
    } qual_rule_e;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_WAIT_FIRST = 2'd1,
        ST_COUNT_REST = 2'd2,
        ST_FIRED      = 2'd3
    } trig_state_e;

endpackage

// File: rtl/tqp_sampler.sv
// Registers the thresholded channels once and keeps the previous sample
// for edge detection.
module tqp_sampler #(
    parameter int NCH = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] chan,
    output logic [NCH-1:0] cur_q,
    output logic [NCH-1:0] prv_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
            prv_q <= '0;
        end else begin
            cur_q <= chan;
            prv_q <= cur_q;
        end
    end

endmodule

// File: rtl/tqp_pattern_timer.sv
// Per-channel pattern compare (R4) and saturating run-length counter.
// run_len is the number of consecutive matching samples before the
// current one; it clears the sample after a mismatch (R8).
module tqp_pattern_timer #(
    parameter int NCH   = 4,
    parameter int DUR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCH-1:0]   cur,
    input  logic [NCH-1:0]   care,
    input  logic [NCH-1:0]   val,
    output logic             match,
    output logic [DUR_W-1:0] run_len
);

    localparam logic [DUR_W-1:0] RUN_MAX = '1;

    logic [NCH-1:0] bit_ok;

    for (genvar i = 0; i < NCH; i++) begin : g_bit
        assign bit_ok[i] = ~care[i] | (cur[i] == val[i]);
    end

    assign match = &bit_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_len <= '0;
        end else if (!match) begin
            run_len <= '0;
        end else if (run_len != RUN_MAX) begin
            run_len <= run_len + 1'b1;
        end
    end

endmodule

// File: rtl/tqp_event_det.sv
// Turns the sampled stream into two event strobes: ev_first must satisfy
// the full condition (duration rule in mode 3), ev_rest is what counts
// after the first event (R9).
module tqp_event_det
    import tqp_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int DUR_W = 8,
    parameter int SEL_W = 2
) (
    input  trig_mode_e       mode,
    input  logic [NCH-1:0]   cur,
    input  logic [NCH-1:0]   prv,
    input  logic [SEL_W-1:0] edge_sel,
    input  logic             edge_rise,
    input  logic             match,
    input  logic [DUR_W-1:0] run_len,
    input  logic             pat_exit,
    input  qual_rule_e       rule,
    input  logic [DUR_W-1:0] dur_lo,
    input  logic [DUR_W-1:0] dur_hi,
    input  logic [DUR_W-1:0] min_len,
    output logic             ev_first,
    output logic             ev_rest
);

    logic [DUR_W-1:0] min_eff;
    logic             enter_hit;
    logic             exit_hit;
    logic             edge_hit;
    logic             rule_ok;
    logic             cur_bit;
    logic             prv_bit;

    // R6: zero minimum behaves as one sample
    assign min_eff = (min_len == '0) ? {{(DUR_W-1){1'b0}}, 1'b1} : min_len;

    // R5: entry once held min_eff samples; exit after a long enough run
    assign enter_hit = match && (run_len == min_eff - 1'b1);
    assign exit_hit  = !match && (run_len >= min_eff);

    // R3: selected channel, selected polarity
    assign cur_bit  = cur[edge_sel];
    assign prv_bit  = prv[edge_sel];
    assign edge_hit = edge_rise ? (cur_bit & ~prv_bit) : (~cur_bit & prv_bit);

    // R7: duration rule on the run just ended
    always_comb begin
        unique case (rule)
            RULE_GT:     rule_ok = run_len > dur_lo;
            RULE_LT:     rule_ok = run_len < dur_hi;
            RULE_IN,
            RULE_IN_ALT: rule_ok = (run_len >= dur_lo) && (run_len <= dur_hi);
        endcase
    end

    always_comb begin
        unique case (mode)
            MODE_IMM: begin
                ev_first = 1'b0;
                ev_rest  = 1'b0;
            end
            MODE_EDGE: begin
                ev_first = edge_hit;
                ev_rest  = edge_hit;
            end
            MODE_PAT: begin
                ev_first = pat_exit ? exit_hit : enter_hit;
                ev_rest  = pat_exit ? exit_hit : enter_hit;
            end
            MODE_TQUAL: begin
                ev_first = exit_hit && rule_ok;
                ev_rest  = exit_hit;
            end
        endcase
    end

endmodule

// File: rtl/tqp_ctrl.sv
// Trigger state machine with event counter and timeout timer.
module tqp_ctrl
    import tqp_pkg::*;
#(
    parameter int EVT_W  = 4,
    parameter int AUTO_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  trig_mode_e        mode,
    input  logic              ev_first,
    input  logic              ev_rest,
    input  logic [EVT_W-1:0]  evt_n,
    input  logic              auto_en,
    input  logic [AUTO_W-1:0] auto_limit,
    output logic              trig,
    output logic              trig_auto,
    output logic              armed
);

    localparam logic [AUTO_W-1:0] TMR_MAX = '1;

    trig_state_e       state_q;
    trig_state_e       state_d;
    logic [EVT_W-1:0]  hit_q;
    logic [AUTO_W-1:0] tmr_q;
    logic              auto_q;
    logic              fire_auto;
    logic              auto_hit;
    logic              mode_imm;
    logic [EVT_W:0]    n_eff;
    logic [EVT_W:0]    hit_nxt;

    assign mode_imm = (mode == MODE_IMM);
    // R9: zero count behaves as one
    assign n_eff    = (evt_n == '0) ? {{EVT_W{1'b0}}, 1'b1} : {1'b0, evt_n};
    assign hit_nxt  = {1'b0, hit_q} + 1'b1;
    // R10: timeout after auto_limit waiting samples
    assign auto_hit = auto_en && (tmr_q >= auto_limit);

    // next-state logic
    always_comb begin
        state_d   = state_q;
        fire_auto = 1'b0;
        if (arm) begin
            state_d = ST_WAIT_FIRST;                         // arm (R11)
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    state_d = ST_IDLE;                       // R12
                end
                ST_WAIT_FIRST: begin
                    if (mode_imm) begin
                        state_d = ST_FIRED;                  // instant (R2)
                    end else if (ev_first) begin
                        state_d = (n_eff == 1) ? ST_FIRED    // first_done
                                               : ST_COUNT_REST; // first_seen
                    end else if (auto_hit) begin
                        state_d   = ST_FIRED;                // timeout
                        fire_auto = 1'b1;
                    end
                end
                ST_COUNT_REST: begin
                    if (mode_imm) begin
                        state_d = ST_FIRED;                  // instant
                    end else if (ev_rest) begin
                        if (hit_nxt == n_eff) begin
                            state_d = ST_FIRED;              // nth_done
                        end
                    end else if (auto_hit) begin
                        state_d   = ST_FIRED;                // timeout
                        fire_auto = 1'b1;
                    end
                end
                ST_FIRED: begin
                    state_d = ST_FIRED;                      // R11 hold
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // event counter, timeout timer, timeout flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit_q  <= '0;
            tmr_q  <= '0;
            auto_q <= 1'b0;
        end else if (arm) begin
            hit_q  <= '0;
            tmr_q  <= '0;
            auto_q <= 1'b0;
        end else begin
            if (state_q == ST_WAIT_FIRST && !mode_imm && ev_first) begin
                hit_q <= {{(EVT_W-1){1'b0}}, 1'b1};
            end else if (state_q == ST_COUNT_REST && !mode_imm && ev_rest) begin
                hit_q <= hit_nxt[EVT_W-1:0];
            end
            if ((state_q == ST_WAIT_FIRST || state_q == ST_COUNT_REST)
                && state_d != ST_FIRED && tmr_q != TMR_MAX) begin
                tmr_q <= tmr_q + 1'b1;
            end
            if (fire_auto) begin
                auto_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        trig      = (state_q == ST_FIRED);
        trig_auto = auto_q;
        armed     = (state_q == ST_WAIT_FIRST) || (state_q == ST_COUNT_REST);
    end

endmodule

// File: rtl/tqp_trigger.sv
module tqp_trigger
    import tqp_pkg::*;
#(
    parameter int NCH    = 4,
    parameter int DUR_W  = 8,
    parameter int EVT_W  = 4,
    parameter int AUTO_W = 16,
    localparam int SEL_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic [NCH-1:0]    chan,
    input  logic [1:0]        mode_cfg,
    input  logic [SEL_W-1:0]  edge_sel,
    input  logic              edge_rise,
    input  logic [NCH-1:0]    pat_care,
    input  logic [NCH-1:0]    pat_val,
    input  logic              pat_exit,
    input  logic [1:0]        qual_rule,
    input  logic [DUR_W-1:0]  dur_lo,
    input  logic [DUR_W-1:0]  dur_hi,
    input  logic [DUR_W-1:0]  min_len,
    input  logic [EVT_W-1:0]  evt_n,
    input  logic              auto_en,
    input  logic [AUTO_W-1:0] auto_limit,
    output logic              trig,
    output logic              trig_auto,
    output logic              armed
);

    trig_mode_e       mode_e;
    qual_rule_e       rule_e;
    logic [NCH-1:0]   cur_q;
    logic [NCH-1:0]   prv_q;
    logic             match;
    logic [DUR_W-1:0] run_len;
    logic             ev_first;
    logic             ev_rest;

    assign mode_e = trig_mode_e'(mode_cfg);
    assign rule_e = qual_rule_e'(qual_rule);

    tqp_sampler #(.NCH(NCH)) u_sampler (
        .clk   (clk),
        .rst_n (rst_n),
        .chan  (chan),
        .cur_q (cur_q),
        .prv_q (prv_q)
    );

    tqp_pattern_timer #(.NCH(NCH), .DUR_W(DUR_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .cur     (cur_q),
        .care    (pat_care),
        .val     (pat_val),
        .match   (match),
        .run_len (run_len)
    );

    tqp_event_det #(.NCH(NCH), .DUR_W(DUR_W), .SEL_W(SEL_W)) u_det (
        .mode      (mode_e),
        .cur       (cur_q),
        .prv       (prv_q),
        .edge_sel  (edge_sel),
        .edge_rise (edge_rise),
        .match     (match),
        .run_len   (run_len),
        .pat_exit  (pat_exit),
        .rule      (rule_e),
        .dur_lo    (dur_lo),
        .dur_hi    (dur_hi),
        .min_len   (min_len),
        .ev_first  (ev_first),
        .ev_rest   (ev_rest)
    );

    tqp_ctrl #(.EVT_W(EVT_W), .AUTO_W(AUTO_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (arm),
        .mode       (mode_e),
        .ev_first   (ev_first),
        .ev_rest    (ev_rest),
        .evt_n      (evt_n),
        .auto_en    (auto_en),
        .auto_limit (auto_limit),
        .trig       (trig),
        .trig_auto  (trig_auto),
        .armed      (armed)
    );

endmodule

// File: rtl/tqp_trigger_chk.sv
module tqp_trigger_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       arm,
    input logic [1:0] mode_cfg,
    input logic       trig,
    input logic       trig_auto,
    input logic       armed
);

    a_r11_trig_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !arm) |=> trig);

    a_r11_arm_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (armed && !trig && !trig_auto));

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !trig && !arm) |=> (!trig && !armed));

    a_r2_immediate_fires: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !arm && mode_cfg == 2'd0) |=> trig);

    a_r10_auto_flag_with_trig: assert property (@(posedge clk) disable iff (!rst_n)
        trig_auto |-> trig);

    a_r11_armed_excludes_trig: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> !trig);

endmodule

bind tqp_trigger tqp_trigger_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .mode_cfg  (mode_cfg),
    .trig      (trig),
    .trig_auto (trig_auto),
    .armed     (armed)
);

// File: tb/tqp_trigger_tb.sv
module tqp_trigger_tb;

    logic        clk;
    logic        rst_n;
    logic        arm;
    logic [3:0]  chan;
    logic [1:0]  mode_cfg;
    logic [1:0]  edge_sel;
    logic        edge_rise;
    logic [3:0]  pat_care;
    logic [3:0]  pat_val;
    logic        pat_exit;
    logic [1:0]  qual_rule;
    logic [7:0]  dur_lo;
    logic [7:0]  dur_hi;
    logic [7:0]  min_len;
    logic [3:0]  evt_n;
    logic        auto_en;
    logic [15:0] auto_limit;
    logic        trig;
    logic        trig_auto;
    logic        armed;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    tqp_trigger u_dut (
        .clk(clk), .rst_n(rst_n), .arm(arm), .chan(chan),
        .mode_cfg(mode_cfg), .edge_sel(edge_sel), .edge_rise(edge_rise),
        .pat_care(pat_care), .pat_val(pat_val), .pat_exit(pat_exit),
        .qual_rule(qual_rule), .dur_lo(dur_lo), .dur_hi(dur_hi),
        .min_len(min_len), .evt_n(evt_n), .auto_en(auto_en),
        .auto_limit(auto_limit), .trig(trig), .trig_auto(trig_auto),
        .armed(armed)
    );

    initial clk = 0;
    always #4 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_arm();
        arm = 1;
        @(negedge clk);
        arm = 0;
    endtask

    task automatic setup(input logic [3:0] idle);
        chan = idle;
        repeat (3) @(negedge clk);
        do_arm();
    endtask

    task automatic pulse(input logic [3:0] v, input logic [3:0] idle, input int len);
        chan = v;
        repeat (len) @(negedge clk);
        chan = idle;
    endtask

    task automatic pat_cfg(input logic [1:0] m, input logic ex, input logic [7:0] mn);
        mode_cfg = m; pat_exit = ex; min_len = mn;
        pat_care = 4'hF; pat_val = 4'h5;
        evt_n = 4'd1; auto_en = 0; auto_limit = 16'd0;
    endtask

    initial begin
        rst_n = 0; arm = 0; chan = 4'hA; mode_cfg = 2'd2; edge_sel = 0;
        edge_rise = 1; pat_care = 4'hF; pat_val = 4'h5; pat_exit = 0;
        qual_rule = 0; dur_lo = 0; dur_hi = 0; min_len = 1; evt_n = 1;
        auto_en = 0; auto_limit = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 trig", trig, 0);
        chk("R1 trig_auto", trig_auto, 0);
        chk("R1 armed", armed, 0);
        rst_n = 1;
        @(negedge clk);

        // R12: activity while not armed
        pat_cfg(2'd2, 1'b0, 8'd1);
        pulse(4'h5, 4'hA, 3);
        repeat (3) @(negedge clk);
        chk("R12 no trig unarmed", trig, 0);

        // R2 immediate mode, R11 hold and re-arm
        mode_cfg = 2'd0;
        do_arm();
        chk("R2 armed after arm", armed, 1);
        chk("R2 not yet", trig, 0);
        @(negedge clk);
        chk("R2 immediate fire", trig, 1);
        repeat (5) @(negedge clk);
        chk("R11 trig held", trig, 1);
        mode_cfg = 2'd2;
        do_arm();
        chk("R11 re-arm clears trig", trig, 0);
        chk("R11 re-arm armed", armed, 1);

        // R3 edge sweep
        for (int ch = 0; ch < 4; ch++) begin
            for (int pol = 0; pol < 2; pol++) begin
                logic [3:0] sel_m, base;
                sel_m = 4'(1 << ch);
                base = pol[0] ? sel_m : ~sel_m;
                pat_cfg(2'd1, 1'b0, 8'd1);
                edge_sel = 2'(ch); edge_rise = pol[0];
                setup(base);
                chan = chan ^ sel_m;           // wrong polarity
                repeat (3) @(negedge clk);
                chk("R3 wrong polarity ignored", trig, 0);
                chan = chan ^ ~sel_m;          // other channels
                repeat (3) @(negedge clk);
                chk("R3 other channels ignored", trig, 0);
                chan = chan ^ sel_m;           // selected edge
                @(negedge clk);
                chk("R3 latency low", trig, 0);
                @(negedge clk);
                chk("R3 edge fires", trig, 1);
            end
        end

        // R4 care/value sweep
        for (int v = 0; v < 16; v++) begin
            pat_cfg(2'd2, 1'b0, 8'd1);
            pat_care = 4'b1011; pat_val = 4'b1001;
            setup(4'b0010);
            chan = 4'(v);
            repeat (3) @(negedge clk);
            chk("R4 pattern compare", trig,
                ((4'(v) & 4'b1011) == (4'b1001 & 4'b1011)) ? 1 : 0);
        end

        // R5 entry latency with minimum length 3, R6 short pulse
        pat_cfg(2'd2, 1'b0, 8'd3);
        setup(4'hA);
        pulse(4'h5, 4'hA, 2);
        repeat (3) @(negedge clk);
        chk("R6 entry short ignored", trig, 0);
        chan = 4'h5;
        repeat (3) @(negedge clk);
        chk("R5 entry before min", trig, 0);
        @(negedge clk);
        chk("R5 entry fires", trig, 1);

        // R5 exit mode: not while held, fires after exit
        pat_cfg(2'd2, 1'b1, 8'd3);
        setup(4'hA);
        pulse(4'h5, 4'hA, 2);
        repeat (3) @(negedge clk);
        chk("R6 exit short ignored", trig, 0);
        pulse(4'h5, 4'hA, 6);
        chk("R5 no fire while held", trig, 0);
        @(negedge clk);
        chk("R5 exit latency low", trig, 0);
        @(negedge clk);
        chk("R5 exit fires", trig, 1);

        // R6 min_len 0 acts as 1
        pat_cfg(2'd2, 1'b0, 8'd0);
        setup(4'hA);
        pulse(4'h5, 4'hA, 1);
        repeat (3) @(negedge clk);
        chk("R6 zero min acts as one", trig, 1);

        // R7 duration rule sweep
        for (int r = 0; r < 4; r++) begin
            for (int len = 1; len <= 10; len++) begin
                int exp;
                pat_cfg(2'd3, 1'b1, 8'd1);
                qual_rule = 2'(r); dur_lo = 8'd4; dur_hi = 8'd7;
                if (r == 0) exp = (len > 4) ? 1 : 0;
                else if (r == 1) exp = (len < 7) ? 1 : 0;
                else exp = (len >= 4 && len <= 7) ? 1 : 0;
                setup(4'hA);
                pulse(4'h5, 4'hA, len);
                repeat (3) @(negedge clk);
                chk("R7 duration rule", trig, exp);
            end
        end

        // R8 failed pattern, new pattern on next sample
        pat_cfg(2'd3, 1'b1, 8'd1);
        qual_rule = 2'd0; dur_lo = 8'd4;
        setup(4'hA);
        pulse(4'h5, 4'hA, 3);
        @(negedge clk);
        pulse(4'h5, 4'hA, 5);
        repeat (3) @(negedge clk);
        chk("R8 rearm after failure", trig, 1);

        // R9 event count sweep in pattern-entry mode
        for (int n = 0; n < 5; n++) begin
            for (int p = 0; p < 5; p++) begin
                int need;
                need = (n == 0) ? 1 : n;
                pat_cfg(2'd2, 1'b0, 8'd1);
                evt_n = 4'(n);
                setup(4'hA);
                for (int k = 0; k < p; k++) begin
                    pulse(4'h5, 4'hA, 2);
                    repeat (2) @(negedge clk);
                end
                repeat (3) @(negedge clk);
                chk("R9 nth event", trig, (p >= need) ? 1 : 0);
            end
        end

        // R9 only the first counted pattern is time-qualified
        pat_cfg(2'd3, 1'b1, 8'd1);
        qual_rule = 2'd0; dur_lo = 8'd4; evt_n = 4'd3;
        setup(4'hA);
        pulse(4'h5, 4'hA, 2); repeat (2) @(negedge clk);
        pulse(4'h5, 4'hA, 6); repeat (2) @(negedge clk);
        pulse(4'h5, 4'hA, 1); repeat (3) @(negedge clk);
        chk("R9 two counted", trig, 0);
        pulse(4'h5, 4'hA, 1); repeat (3) @(negedge clk);
        chk("R9 third unqualified counts", trig, 1);
        setup(4'hA);
        for (int k = 0; k < 4; k++) begin
            pulse(4'h5, 4'hA, 2); repeat (2) @(negedge clk);
        end
        repeat (2) @(negedge clk);
        chk("R9 unqualified first never counts", trig, 0);

        // R10 timeout latency sweep
        for (int lim = 0; lim < 7; lim += 3) begin
            pat_cfg(2'd2, 1'b0, 8'd1);
            auto_en = 1; auto_limit = 16'(lim);
            setup(4'hA);
            repeat (lim) @(negedge clk);
            chk("R10 before timeout", trig, 0);
            @(negedge clk);
            chk("R10 timeout trig", trig, 1);
            chk("R10 timeout flag", trig_auto, 1);
        end
        pat_cfg(2'd2, 1'b0, 8'd1);
        auto_en = 0; auto_limit = 16'd0;
        setup(4'hA);
        repeat (20) @(negedge clk);
        chk("R10 disabled timeout", trig, 0);
        auto_en = 1; auto_limit = 16'd20;
        setup(4'hA);
        pulse(4'h5, 4'hA, 2);
        repeat (3) @(negedge clk);
        chk("R10 real event trig", trig, 1);
        chk("R10 real event no flag", trig_auto, 0);
        do_arm();
        chk("R11 re-arm clears flag", trig_auto, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule